// File: doc/BRIEF.md
# Serial Command Register Controller

This block is a slave-only two-wire serial port with a command interpreter, meant to sit in the control section of a video front-end. It watches the clock and data lines from an external master, finds START, repeated START and STOP conditions, checks a 7-bit slave address, and takes command and data bytes in nine-clock frames (eight data bits and one acknowledge bit). The data line is open-drain: the block can only pull it low or let it go.

Accepted command bytes change three registers. The first is a control/status byte whose bit 0 drives a power-down output. The second is a channel-select register with four 2-bit source selects (three video inputs and one external sync input) and a copy of the last chosen code. The third is a frequency byte that can only be written through an arming command. Other commands power down, wake up, soft-reset the control byte, or choose which register a read transaction returns. Invalid bytes are refused with a NACK and change nothing.

Top module: `i2c_cmd_regctl`

## Requirements
- R1: After the synchronous reset `sda_drive_low` is 0, `pwr_down` is 0, `ctrl_status` is 8'h00, `chan_sel` is all zero, `freq_val` equals parameter FREQ_RST (8'h40) and the read pointer selects the control/status byte.
- R2: The first byte after a START is the address, MSB first, with address in bits 7:1 and read (1) / write (0) in bit 0. A match with SLV_ADDR (7'h36) is ACKed by holding SDA low during the ninth clock. A mismatch is not ACKed, and every later byte is ignored (no ACK, no register change) until the next START.
- R3: The command 8'b01mm00cc, with cc not equal to 2'b11, sets select field mm (bits 2mm+1:2mm of `chan_sel`) to cc and copies cc into `chan_sel[9:8]`. The codes are 00 = A, 01 = B and 10 = C.
- R4: A command byte outside the set defined in R3 and R5–R8 is NACKed and changes no register. This includes a select command with cc = 2'b11 or with nonzero bits 3:2.
- R5: Command 8'hA0 sets `ctrl_status[0]` and `pwr_down`, and 8'hA1 clears them. Neither command changes `chan_sel` or `freq_val`, and the serial port keeps working while powered down.
- R6: Command 8'hA5 returns `ctrl_status` to 8'h00 and leaves `chan_sel` and `freq_val` unchanged.
- R7: Command 8'hB0 arms a frequency write. The next byte of the same transaction is ACKed whatever its value and stored in `freq_val`, not decoded as a command. A START or STOP cancels the arming.
- R8: Command 8'b110000pp sets the read pointer: 0 = control/status, 1 = `chan_sel[7:0]`, 2 = {6'b0, `chan_sel[9:8]`}, 3 = frequency. A read transaction returns the pointed register MSB first, and returns it again for every byte the master ACKs. A master NACK ends the read.
- R9: A repeated START in the middle of a transaction restarts address reception without needing a STOP.
- R10: After a STOP, bytes clocked without a new START get no ACK and change no register.
- R11: The block changes `sda_drive_low` only right after an SCL falling edge, so SDA never moves while SCL is high because of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the serial bit rate |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl_in | input | 1 | Serial clock from the master, asynchronous |
| sda_in | input | 1 | Serial data line level, asynchronous |
| sda_drive_low | output | 1 | 1 = pull SDA low, 0 = release it |
| pwr_down | output | 1 | Power-down request to the analog section |
| ctrl_status | output | 8 | Control/status register |
| chan_sel | output | 10 | Four 2-bit selects in bits 7:0, last selected code in bits 9:8 |
| freq_val | output | 8 | Frequency register |

## Verification
The bench targets the selective soft reset. A design that cleared everything on 8'hA5 would lose the channel and frequency settings. It also sends an armed frequency byte whose value is a valid command. A design that decoded that byte would power down or reset instead of storing the frequency. Other cases are a select code of 2'b11, bytes after an address mismatch or after a STOP, and an arming command cut off by a repeated START. Each of these would be ACKed or applied by a design that handled it wrongly. Multi-byte reads and wake-up after power-down show whether the design shifts or loses register state across those transitions.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int N_MUX     = 4;
  localparam int SEL_W     = 2;
  localparam int MUX_IDX_W = $clog2(N_MUX);
  localparam int SELV_W    = N_MUX * SEL_W;
  localparam int CHSEL_W   = SELV_W + SEL_W;
  localparam int BYTE_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_ACK_R
  } bus_st_t;

  localparam logic [7:0] CMD_PDN  = 8'hA0;
  localparam logic [7:0] CMD_WAKE = 8'hA1;
  localparam logic [7:0] CMD_SRST = 8'hA5;
  localparam logic [7:0] CMD_FARM = 8'hB0;
  localparam logic [1:0] SEL_PREFIX = 2'b01;
  localparam logic [5:0] PTR_PREFIX = 6'b110000;
  localparam logic [1:0] SEL_BAD    = 2'b11;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_in};
      sda_sh <= {sda_sh[MSB-1:0], sda_in};
      scl_q  <= scl_sh[MSB];
      sda_q  <= sda_sh[MSB];
    end
  end

  assign scl_lvl   = scl_sh[MSB];
  assign sda_lvl   = sda_sh[MSB];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign bus_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              wr_accept,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_low,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  bus_st_t           st;
  logic [3:0]        bcnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      sda_low <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (bus_stop) begin
        st      <= ST_IDLE;
        sda_low <= 1'b0;
      end else if (bus_start) begin
        st      <= ST_ADDR;
        bcnt    <= '0;
        sda_low <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              bcnt  <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == LAST_BIT) begin
              bcnt <= '0;
              if (st == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == SLV_ADDR) begin
                  sda_low <= 1'b1;
                  rw      <= shreg[0];
                  st      <= ST_ACK_A;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                wr_stb  <= 1'b1;
                sda_low <= wr_accept;
                st      <= ST_ACK_W;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              bcnt <= '0;
              if (rw) begin
                shreg   <= rd_data;
                sda_low <= ~rd_data[BYTE_W-1];
                st      <= ST_RD;
              end else begin
                sda_low <= 1'b0;
                st      <= ST_WR;
              end
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              st      <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall) begin
              if (bcnt == LAST_BIT) begin
                sda_low <= 1'b0;
                bcnt    <= '0;
                st      <= ST_ACK_R;
              end else begin
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                sda_low <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_ACK_R: begin
            if (scl_rise && sda_lvl) begin
              st <= ST_IDLE;
            end else if (scl_fall) begin
              shreg   <= rd_data;
              sda_low <= ~rd_data[BYTE_W-1];
              bcnt    <= '0;
              st      <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_byte = shreg;
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
#(
  parameter logic [7:0] FREQ_RST = 8'h40,
  parameter logic [7:0] CTRL_RST = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               wr_stb,
  input  logic [BYTE_W-1:0]  wr_byte,
  output logic               wr_accept,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [BYTE_W-1:0]  ctrl_status,
  output logic [CHSEL_W-1:0] chan_sel,
  output logic [BYTE_W-1:0]  freq_val
);
  logic [BYTE_W-1:0] ctrl_q, freq_q;
  logic [SEL_W-1:0]  sel_q [N_MUX];
  logic [SEL_W-1:0]  last_q;
  logic [SELV_W-1:0] sel_vec;
  logic [1:0]        rd_ptr;
  logic              freq_pend;
  logic              is_sel, is_ptr, take, do_sel;

  assign is_sel = (wr_byte[7:6] == SEL_PREFIX) && (wr_byte[3:2] == 2'b00)
                  && (wr_byte[1:0] != SEL_BAD);
  assign is_ptr = (wr_byte[7:2] == PTR_PREFIX);
  assign wr_accept = freq_pend | is_sel | is_ptr | (wr_byte == CMD_PDN)
                   | (wr_byte == CMD_WAKE) | (wr_byte == CMD_SRST)
                   | (wr_byte == CMD_FARM);
  assign take   = wr_stb & wr_accept;
  assign do_sel = take & ~freq_pend & is_sel;

  generate
    for (genvar k = 0; k < N_MUX; k++) begin : g_mux
      always_ff @(posedge clk) begin
        if (rst)
          sel_q[k] <= '0;
        else if (do_sel && wr_byte[4 +: MUX_IDX_W] == MUX_IDX_W'(k))
          sel_q[k] <= wr_byte[SEL_W-1:0];
      end
      assign sel_vec[k*SEL_W +: SEL_W] = sel_q[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      freq_q    <= FREQ_RST;
      last_q    <= '0;
      rd_ptr    <= '0;
      freq_pend <= 1'b0;
    end else if (bus_start || bus_stop) begin
      freq_pend <= 1'b0;
    end else if (take) begin
      if (freq_pend) begin
        freq_q    <= wr_byte;
        freq_pend <= 1'b0;
      end else if (is_sel) begin
        last_q <= wr_byte[SEL_W-1:0];
      end else if (is_ptr) begin
        rd_ptr <= wr_byte[1:0];
      end else begin
        unique case (wr_byte)
          CMD_PDN:  ctrl_q[0] <= 1'b1;
          CMD_WAKE: ctrl_q[0] <= 1'b0;
          CMD_SRST: ctrl_q    <= CTRL_RST;
          CMD_FARM: freq_pend <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (rd_ptr)
      2'd0:    rd_data = ctrl_q;
      2'd1:    rd_data = sel_vec;
      2'd2:    rd_data = {{(BYTE_W-SEL_W){1'b0}}, last_q};
      default: rd_data = freq_q;
    endcase
  end

  assign ctrl_status = ctrl_q;
  assign chan_sel    = {last_q, sel_vec};
  assign freq_val    = freq_q;
endmodule

// File: rtl/i2c_cmd_regctl.sv
module i2c_cmd_regctl
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h36,
  parameter logic [7:0] FREQ_RST    = 8'h40,
  parameter logic [7:0] CTRL_RST    = 8'h00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_drive_low,
  output logic        pwr_down,
  output logic [7:0]  ctrl_status,
  output logic [9:0]  chan_sel,
  output logic [7:0]  freq_val
);
  logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_accept, wr_stb;
  logic [BYTE_W-1:0] wr_byte, rd_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_byte_engine #(.SLV_ADDR(SLV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .wr_accept(wr_accept), .rd_data(rd_data), .sda_low(sda_drive_low),
    .wr_stb(wr_stb), .wr_byte(wr_byte)
  );

  i2c_cmd_regs #(.FREQ_RST(FREQ_RST), .CTRL_RST(CTRL_RST)) u_regs (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .wr_accept(wr_accept),
    .rd_data(rd_data), .ctrl_status(ctrl_status), .chan_sel(chan_sel),
    .freq_val(freq_val)
  );

  assign pwr_down = ctrl_status[0];
endmodule

// File: rtl/i2c_cmd_regctl_chk.sv
module i2c_cmd_regctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sda_drive_low,
  input logic       scl_fall,
  input logic       wr_stb,
  input logic [7:0] wr_byte,
  input logic [7:0] ctrl_status,
  input logic [9:0] chan_sel,
  input logic [7:0] freq_val
);
  generate
    for (genvar k = 0; k < 5; k++) begin : g_code
      assert_sel_code_R4: assert property (@(posedge clk) disable iff (rst)
        chan_sel[2*k +: 2] != 2'b11);
    end
  endgenerate

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_sel) |-> $past(wr_stb));

  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_status) |-> $past(wr_stb));

  assert_freq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_val) |-> $past(wr_stb));

  assert_srst_keeps_sel_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_byte == 8'hA5) |=> $stable(chan_sel));

  assert_sda_edge_R11: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_drive_low) || $fell(sda_drive_low)) |-> $past(scl_fall));
endmodule

bind i2c_cmd_regctl i2c_cmd_regctl_chk u_chk (
  .clk(clk), .rst(rst), .sda_drive_low(sda_drive_low), .scl_fall(scl_fall),
  .wr_stb(wr_stb), .wr_byte(wr_byte), .ctrl_status(ctrl_status),
  .chan_sel(chan_sel), .freq_val(freq_val)
);

// File: tb/i2c_cmd_regctl_test.sv
module i2c_cmd_regctl_test;
  localparam int CLK_NS = 10;
  localparam int HP = 12;
  localparam logic [6:0] ADDR = 7'h36;
  localparam logic [7:0] FREQ_DEF = 8'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic drv, pd;
  logic [7:0] ctrl, freq;
  logic [9:0] csel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_ctrl, m_freq;
  logic [9:0] m_sel;
  bit m_pend;

  always #(CLK_NS/2) clk = ~clk;
  assign sda_bus = sda_m & ~drv;

  i2c_cmd_regctl uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
    .sda_drive_low(drv), .pwr_down(pd), .ctrl_status(ctrl),
    .chan_sel(csel), .freq_val(freq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit m_ok(logic [7:0] b);
    return m_pend || (b[7:6] == 2'b01 && b[3:2] == 2'b00 && b[1:0] != 2'b11)
      || b == 8'hA0 || b == 8'hA1 || b == 8'hA5 || b == 8'hB0
      || b[7:2] == 6'b110000;
  endfunction

  function automatic logic [7:0] m_rd(int p);
    case (p)
      0: return m_ctrl;
      1: return m_sel[7:0];
      2: return {6'b0, m_sel[9:8]};
      default: return m_freq;
    endcase
  endfunction

  task automatic m_apply(logic [7:0] b);
    if (!m_ok(b)) return;
    if (m_pend) begin m_freq = b; m_pend = 0; end
    else if (b[7:6] == 2'b01) begin
      m_sel[b[5:4]*2 +: 2] = b[1:0];
      m_sel[9:8] = b[1:0];
    end
    else if (b == 8'hA0) m_ctrl[0] = 1'b1;
    else if (b == 8'hA1) m_ctrl[0] = 1'b0;
    else if (b == 8'hA5) m_ctrl = 8'h00;
    else if (b == 8'hB0) m_pend = 1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(HP);
    scl = 1'b1; wt(HP);
    sda_m = 1'b0; wt(HP);
    scl = 1'b0; wt(HP);
    m_pend = 0;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(HP);
    scl = 1'b1; wt(HP);
    sda_m = 1'b1; wt(HP);
    m_pend = 0;
  endtask

  task automatic wr_byte(logic [7:0] b, output bit ack, output bit steady);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HP);
      scl = 1'b1; wt(HP);
      scl = 1'b0;
    end
    sda_m = 1'b1; wt(HP);
    scl = 1'b1; wt(2);
    a1 = sda_bus; wt(HP-2);
    a2 = sda_bus;
    scl = 1'b0;
    ack = ~a2;
    steady = (a1 == a2);
  endtask

  task automatic rd_byte(bit m_ack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HP);
      scl = 1'b1; wt(HP/2);
      v[i] = sda_bus; wt(HP/2);
      scl = 1'b0;
    end
    sda_m = m_ack ? 1'b0 : 1'b1; wt(HP);
    scl = 1'b1; wt(HP);
    scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic send(logic [7:0] b, string tag);
    bit ack, st;
    bit exp = m_ok(b);
    wr_byte(b, ack, st);
    chk(tag, ack, exp);
    chk("R11 ack level steady while SCL high", st, 1);
    m_apply(b);
  endtask

  task automatic addr(bit rd);
    bit ack, st;
    wr_byte({ADDR, rd}, ack, st);
    chk("R2 address ack", ack, 1);
  endtask

  task automatic ports(string tag);
    chk({tag, " pwr_down"}, pd, m_ctrl[0]);
    chk({tag, " ctrl_status"}, ctrl, m_ctrl);
    chk({tag, " chan_sel"}, csel, m_sel);
    chk({tag, " freq_val"}, freq, m_freq);
  endtask

  task automatic read_reg(int p, int nbytes);
    logic [7:0] v;
    i2c_start(); addr(0);
    send(8'hC0 | 8'(p), "R8 pointer command");
    i2c_start(); addr(1);
    for (int i = 0; i < nbytes; i++) begin
      rd_byte(i != nbytes-1, v);
      chk("R8 read back", v, m_rd(p));
    end
    i2c_stop();
  endtask

  task automatic read_all();
    for (int p = 0; p < 4; p++) read_reg(p, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack, st;
    logic [7:0] b;
    void'($urandom(32'd4711));
    m_ctrl = 8'h00; m_freq = FREQ_DEF; m_sel = '0; m_pend = 0;
    wt(10); rst = 1'b0; wt(5);
    chk("R1 sda released", drv, 0);
    ports("R1 reset");
    read_reg(0, 1);

    // R3 channel selects
    i2c_start(); addr(0);
    send(8'h51, "R3 select mux1=B");
    send(8'h72, "R3 select mux3=C");
    send(8'h41, "R3 select mux0=B");
    i2c_stop(); ports("R3");

    // R4 invalid bytes
    i2c_start(); addr(0);
    send(8'h53, "R4 select code 11 nack");
    send(8'h56, "R4 select reserved bits nack");
    send(8'h00, "R4 zero byte nack");
    send(8'hA3, "R4 unused command nack");
    i2c_stop(); ports("R4 unchanged");

    // R7 frequency, data byte equal to a command
    i2c_start(); addr(0);
    send(8'hB0, "R7 arm"); send(8'h9C, "R7 data");
    send(8'hB0, "R7 arm"); send(8'hA5, "R7 data looks like reset");
    i2c_stop(); ports("R7");

    // R5 power down / wake
    i2c_start(); addr(0); send(8'hA0, "R5 power down"); i2c_stop();
    ports("R5 powered down");
    read_all();
    i2c_start(); addr(0); send(8'hA1, "R5 wake"); i2c_stop();
    ports("R5 woken");

    // R6 soft reset
    i2c_start(); addr(0); send(8'hA0, "R6 pd"); send(8'hA5, "R6 srst"); i2c_stop();
    ports("R6 after soft reset");

    // R8 multi-byte read
    read_reg(1, 3);
    read_reg(3, 2);

    // R2 address mismatch
    i2c_start();
    wr_byte({ADDR ^ 7'h01, 1'b0}, ack, st);
    chk("R2 mismatch no ack", ack, 0);
    wr_byte(8'hA0, ack, st);
    chk("R2 ignored after mismatch", ack, 0);
    i2c_stop(); ports("R2 unchanged");

    // R10 bytes after stop
    wr_byte(8'hA0, ack, st);
    chk("R10 no ack without start", ack, 0);
    i2c_stop(); ports("R10 unchanged");

    // R9 repeated start
    i2c_start(); addr(0); send(8'hA0, "R9 pd");
    i2c_start(); addr(0); send(8'hA1, "R9 wake after restart");
    send(8'hB0, "R9 arm");
    i2c_start(); addr(0); send(8'h11, "R9 arming cancelled, nack");
    i2c_stop(); ports("R9");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom % 3);
      i2c_start(); addr(0);
      for (int j = 0; j < n; j++) begin
        case ($urandom % 8)
          0, 1: b = {2'b01, 2'($urandom), 2'b00, 2'($urandom)};
          2: b = 8'hA0;
          3: b = 8'hA1;
          4: b = 8'hA5;
          5: b = 8'hB0;
          6: b = 8'($urandom);
          default: b = {6'b110000, 2'($urandom)};
        endcase
        send(b, "R3 R4 R5 R6 R7 random command ack");
      end
      i2c_stop();
      ports("R3 R5 R6 R7 random");
      if (t % 10 == 9) read_all();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule